// File: doc/BRIEF.md
# Multiprocessor Receiver Wake-Up Controller

This block sits beside a serial receiver on a shared multi-drop line and decides when a sleeping node starts accepting characters again. Software puts the receiver to sleep once it sees that a message is not meant for its node. While the flag is set, received characters raise no receive-full pulse. Hardware clears the flag when the chosen wake condition occurs. The deserializer itself is outside the block. It supplies a bit-time strobe, a character-received strobe and the received character. The block returns a gated receive-full pulse together with the character.

There are two wake methods, and the mode select picks one. In idle-line mode the node wakes after the line has stayed high for a whole character time. That is ten bit times with 8-bit frames and eleven with 9-bit frames. Senders must therefore leave a gap between messages but no gap inside one. In address-mark mode the top bit of each character marks it as an address (1) or as data (0). A sleeping node wakes on the first address character and passes that character on as the first one it receives. Idle gaps have no effect in this mode.

Top module: `rx_wake_ctrl`

## Requirements
- R1: After reset `sleep_o` is 0 and `rx_full_o` is 0.
- R2: A cycle with `sleep_req_i` high sets `sleep_o` at the next clock edge. The request wins over a wake condition in the same cycle.
- R3: In idle-line mode (`mode_addr_i`=0) with 8-bit frames (`frame9_i`=0), a sleeping node clears `sleep_o` at the edge that samples the 10th bit strobe. The line must have been high in every cycle since counting began. No other event clears the flag in this mode.
- R4: In idle-line mode with 9-bit frames (`frame9_i`=1), the same wake-up needs 11 consecutive high bit strobes.
- R5: In idle-line mode, any clock cycle with `line_i` low while asleep restarts the idle count from zero, and that cycle cannot wake the node.
- R6: In idle-line mode, characters received while asleep produce no `rx_full_o` pulse, whatever their top bit.
- R7: In address-mark mode (`mode_addr_i`=1), a data character (top bit 0) received while asleep produces no `rx_full_o` pulse and leaves `sleep_o` set. An idle line of any length does not wake the node.
- R8: In address-mark mode, a sleeping node clears `sleep_o` at the edge that samples an address character. The top bit is `char_data_i[7]` with 8-bit frames and `char_data_i[8]` with 9-bit frames.
- R9: In address-mark mode, the waking address character is delivered. `rx_full_o` is high for one cycle after the strobe, and `rx_data_o` carries the character.
- R10: While awake, every character strobe gives a one-cycle `rx_full_o` pulse in the next cycle, with `rx_data_o` equal to the character, whatever its top bit. `sleep_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Serial line level (1 = idle/mark) |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| char_valid_i | input | 1 | One-cycle strobe when a character has been received |
| char_data_i | input | DATA_BITS+1 | Received character (9-bit frames use the top bit) |
| mode_addr_i | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| frame9_i | input | 1 | 1 = 9-bit frames, 0 = 8-bit frames |
| sleep_req_i | input | 1 | Software request to enter sleep |
| sleep_o | output | 1 | Sleep flag |
| rx_full_o | output | 1 | Gated receive-full pulse |
| rx_data_o | output | DATA_BITS+1 | Character delivered with `rx_full_o` |

## Verification
The hardest case to reach from the ports is the idle-line wake-up. It needs ten or eleven bit strobes in a row with no low cycle in between. Random line noise almost never allows that, and a single low near the end must restart the count. The bench therefore drives directed runs that stop one strobe short, insert a single low cycle, and then complete the count. Its random segments pick a per-segment noise rate that includes zero, so long clean stretches do occur. A directed case also makes a sleep request coincide with a waking address character, to show that the request wins while the character is still delivered.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic {
      WAKE_IDLE = 1'b0,
      WAKE_ADDR = 1'b1
   } wake_mode_e;

   // Character time in bit periods: start + data + stop, plus one for the ninth bit.
   function automatic int unsigned char_time(int unsigned data_bits, logic nine);
      return data_bits + 2 + (nine ? 1 : 0);
   endfunction

endpackage

// File: rtl/rxw_line_sync.sv
module rxw_line_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rxw_idle_count.sv
module rxw_idle_count
   import rxw_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8,
   localparam int unsigned CNT_W    = $clog2(DATA_BITS + 4)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic line_i,
   input  logic tick_i,
   input  logic frame9_i,
   output logic done_o
);

   localparam int unsigned LIM8 = char_time(DATA_BITS, 1'b0);
   localparam int unsigned LIM9 = char_time(DATA_BITS, 1'b1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = frame9_i ? CNT_W'(LIM9) : CNT_W'(LIM8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i || !line_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q < limit)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // Fires on the strobe that completes a full character time of high line.
   assign done_o = !clear_i && line_i && tick_i && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/rxw_addr_detect.sv
module rxw_addr_detect #(
   parameter int unsigned DATA_BITS = 8,
   localparam int unsigned CHAR_W   = DATA_BITS + 1
) (
   input  logic [CHAR_W-1:0] char_i,
   input  logic              frame9_i,
   output logic              is_addr_o
);

   assign is_addr_o = frame9_i ? char_i[CHAR_W-1] : char_i[CHAR_W-2];

endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl
   import rxw_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned CHAR_W     = DATA_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic              bit_tick_i,
   input  logic              char_valid_i,
   input  logic [CHAR_W-1:0] char_data_i,
   input  logic              mode_addr_i,
   input  logic              frame9_i,
   input  logic              sleep_req_i,
   output logic              sleep_o,
   output logic              rx_full_o,
   output logic [CHAR_W-1:0] rx_data_o
);

   generate
      if (DATA_BITS < 5 || DATA_BITS > 16) begin : g_bad_width
         $error("rx_wake_ctrl: DATA_BITS must lie in 5..16");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("rx_wake_ctrl: SYNC_STAGES must be 0, 2, 3 or 4");
      end
   endgenerate

   wake_mode_e mode;
   logic       line_s;
   logic       sleep_q;
   logic       idle_done;
   logic       is_addr;
   logic       addr_hit;
   logic       idle_hit;
   logic       deliver;

   assign mode = wake_mode_e'(mode_addr_i);

   rxw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_i),
      .q_o   (line_s)
   );

   rxw_idle_count #(.DATA_BITS(DATA_BITS)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (!sleep_q || sleep_req_i),
      .line_i   (line_s),
      .tick_i   (bit_tick_i),
      .frame9_i (frame9_i),
      .done_o   (idle_done)
   );

   rxw_addr_detect #(.DATA_BITS(DATA_BITS)) u_addr (
      .char_i    (char_data_i),
      .frame9_i  (frame9_i),
      .is_addr_o (is_addr)
   );

   assign addr_hit = sleep_q && (mode == WAKE_ADDR) && char_valid_i && is_addr;
   assign idle_hit = sleep_q && (mode == WAKE_IDLE) && idle_done;
   assign deliver  = char_valid_i && (!sleep_q || addr_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q   <= 1'b0;
         rx_full_o <= 1'b0;
         rx_data_o <= '0;
      end else begin
         if (sleep_req_i)                sleep_q <= 1'b1;
         else if (addr_hit || idle_hit)  sleep_q <= 1'b0;
         rx_full_o <= deliver;
         if (deliver) rx_data_o <= char_data_i;
      end
   end

   assign sleep_o = sleep_q;

endmodule

// File: rtl/rx_wake_ctrl_chk.sv
module rx_wake_ctrl_chk #(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned CHAR_W     = DATA_BITS + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_i,
   input logic              bit_tick_i,
   input logic              char_valid_i,
   input logic [CHAR_W-1:0] char_data_i,
   input logic              mode_addr_i,
   input logic              frame9_i,
   input logic              sleep_req_i,
   input logic              sleep_o,
   input logic              rx_full_o,
   input logic [CHAR_W-1:0] rx_data_o
);

   logic top_bit;
   assign top_bit = frame9_i ? char_data_i[CHAR_W-1] : char_data_i[CHAR_W-2];

   assert_full_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full_o |-> $past(char_valid_i));

   assert_sleep_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req_i |=> sleep_o);

   assert_idle_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !mode_addr_i && !bit_tick_i) |=> sleep_o);

   generate
      if (SYNC_STAGES == 0) begin : g_low_check
         assert_low_blocks_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (sleep_o && !mode_addr_i && !line_i) |=> sleep_o);
      end
   endgenerate

   assert_idle_mode_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && !mode_addr_i) |=> !rx_full_o);

   assert_data_char_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && mode_addr_i && char_valid_i && !top_bit) |=> (!rx_full_o && sleep_o));

   assert_addr_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && mode_addr_i && char_valid_i && top_bit && !sleep_req_i) |=> !sleep_o);

   assert_addr_delivered_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_o && mode_addr_i && char_valid_i && top_bit) |=>
         (rx_full_o && rx_data_o == $past(char_data_i)));

   assert_awake_delivery_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_o && char_valid_i) |=> (rx_full_o && rx_data_o == $past(char_data_i)));

endmodule

bind rx_wake_ctrl rx_wake_ctrl_chk #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/rx_wake_ctrl_bench.sv
module rx_wake_ctrl_bench;

   localparam int unsigned DB = 8;
   localparam int unsigned CW = DB + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_i = 1'b1;
   logic          bit_tick_i = 1'b0;
   logic          char_valid_i = 1'b0;
   logic [CW-1:0] char_data_i = '0;
   logic          mode_addr_i = 1'b0;
   logic          frame9_i = 1'b0;
   logic          sleep_req_i = 1'b0;
   logic          sleep_o;
   logic          rx_full_o;
   logic [CW-1:0] rx_data_o;

   int checks = 0;
   int errors = 0;

   // Reference state
   logic m_sleep = 1'b0;
   int   m_cnt = 0;

   always #10 clk = ~clk;

   rx_wake_ctrl #(.DATA_BITS(DB)) u_rx_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .bit_tick_i(bit_tick_i),
      .char_valid_i(char_valid_i), .char_data_i(char_data_i),
      .mode_addr_i(mode_addr_i), .frame9_i(frame9_i), .sleep_req_i(sleep_req_i),
      .sleep_o(sleep_o), .rx_full_o(rx_full_o), .rx_data_o(rx_data_o)
   );

   function automatic int lim_of(logic f9);
      return f9 ? 11 : 10;
   endfunction

   function automatic logic top_of(logic [CW-1:0] d, logic f9);
      return f9 ? d[8] : d[7];
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock cycle: drive inputs (called at a falling edge), predict, then check at the next falling edge.
   task automatic step(string tag, logic ln, logic tk, logic cv, logic [CW-1:0] d, logic sr);
      int  lim;
      logic ahit, ihit, efull, nsleep;
      int  ncnt;
      line_i = ln; bit_tick_i = tk; char_valid_i = cv; char_data_i = d; sleep_req_i = sr;
      lim    = lim_of(frame9_i);
      ahit   = m_sleep && mode_addr_i && cv && top_of(d, frame9_i);
      ihit   = m_sleep && !mode_addr_i && !sr && ln && tk && (m_cnt == lim - 1);
      efull  = cv && (!m_sleep || ahit);
      ncnt   = (!m_sleep || sr || !ln) ? 0 : ((tk && m_cnt < lim) ? m_cnt + 1 : m_cnt);
      nsleep = sr || (m_sleep && !(ahit || ihit));
      @(posedge clk);
      @(negedge clk);
      m_sleep = nsleep;
      m_cnt   = ncnt;
      check(tag, "sleep_o", int'(sleep_o), int'(nsleep));
      check(tag, "rx_full_o", int'(rx_full_o), int'(efull));
      if (efull) check(tag, "rx_data_o", int'(rx_data_o), int'(d));
   endtask

   task automatic quiet(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 1'b0, '0, 1'b0);
   endtask

   // n bit strobes with the line high, each followed by two quiet cycles
   task automatic high_ticks(string tag, int n);
      for (int i = 0; i < n; i++) begin
         step(tag, 1'b1, 1'b1, 1'b0, '0, 1'b0);
         quiet(tag, 2);
      end
   endtask

   task automatic go_sleep(string tag);
      step(tag, 1'b1, 1'b0, 1'b0, '0, 1'b1);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int lowpct;
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "sleep_o", int'(sleep_o), 0);
      check("R1", "rx_full_o", int'(rx_full_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: sleep request sets the flag
      mode_addr_i = 1'b0; frame9_i = 1'b0;
      go_sleep("R2");
      // R3: 9 strobes keep sleeping, the 10th wakes
      high_ticks("R3", 9);
      check("R3", "asleep after 9", int'(sleep_o), 1);
      high_ticks("R3", 1);
      check("R3", "awake after 10", int'(sleep_o), 0);

      // R5: a single low cycle restarts the count
      go_sleep("R5");
      high_ticks("R5", 9);
      step("R5", 1'b0, 1'b0, 1'b0, '0, 1'b0);
      high_ticks("R5", 9);
      check("R5", "asleep after restart", int'(sleep_o), 1);
      step("R5", 1'b0, 1'b1, 1'b0, '0, 1'b0);
      high_ticks("R5", 10);
      check("R5", "awake after full count", int'(sleep_o), 0);

      // R4: 9-bit frames need 11 strobes
      frame9_i = 1'b1;
      go_sleep("R4");
      high_ticks("R4", 10);
      check("R4", "asleep after 10", int'(sleep_o), 1);
      high_ticks("R4", 1);
      check("R4", "awake after 11", int'(sleep_o), 0);

      // R6: characters ignored while asleep in idle mode
      frame9_i = 1'b0;
      go_sleep("R6");
      step("R6", 1'b0, 1'b0, 1'b1, 9'h1FF, 1'b0);
      step("R6", 1'b0, 1'b0, 1'b1, 9'h055, 1'b0);
      check("R6", "no full", int'(rx_full_o), 0);

      // R7: address mode, data character and long idle do not wake
      mode_addr_i = 1'b1;
      step("R7", 1'b1, 1'b0, 1'b1, 9'h07F, 1'b0);
      high_ticks("R7", 30);
      check("R7", "still asleep", int'(sleep_o), 1);

      // R8 / R9: address character wakes and is delivered (8-bit, bit 7)
      step("R8", 1'b1, 1'b0, 1'b1, 9'h0A3, 1'b0);
      check("R9", "delivered data", int'(rx_data_o), 'h0A3);
      check("R8", "awake", int'(sleep_o), 0);

      // R8: 9-bit frames use bit 8; bit 7 alone is data
      frame9_i = 1'b1;
      go_sleep("R8");
      step("R8", 1'b1, 1'b0, 1'b1, 9'h080, 1'b0);
      check("R8", "bit7 only stays asleep", int'(sleep_o), 1);
      step("R9", 1'b1, 1'b0, 1'b1, 9'h112, 1'b0);
      check("R9", "bit8 wakes", int'(sleep_o), 0);

      // R10: awake delivery regardless of top bit
      step("R10", 1'b0, 1'b0, 1'b1, 9'h000, 1'b0);
      step("R10", 1'b1, 1'b0, 1'b1, 9'h1C4, 1'b0);
      quiet("R10", 1);

      // R2: request coinciding with a waking address character
      go_sleep("R2");
      step("R2", 1'b1, 1'b0, 1'b1, 9'h101, 1'b1);
      check("R2", "request wins", int'(sleep_o), 1);

      // Random segments
      for (int seg = 0; seg < 16; seg++) begin
         mode_addr_i = 1'($urandom % 2);
         frame9_i    = 1'($urandom % 2);
         case ($urandom % 3)
            0: lowpct = 0;
            1: lowpct = 1;
            default: lowpct = 6;
         endcase
         for (int c = 0; c < 300; c++) begin
            logic ln, tk, cv, sr;
            logic [CW-1:0] d;
            ln = !(($urandom % 100) < lowpct);
            tk = ($urandom % 4) == 0;
            cv = ($urandom % 16) == 0;
            d  = CW'($urandom);
            sr = ($urandom % 120) == 0;
            step(mode_addr_i ? "R8" : "R3", ln, tk, cv, d, sr);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule